// File: doc/BRIEF.md
# Gated Activity Watchdog Timer

This block supervises a processor's heartbeat line and drives an active-low alarm output, `wdog_n`. The heartbeat passes through a two-flop synchronizer and a glitch filter. A new level counts as activity only after the filter has seen it for `GLITCH_CYCLES` consecutive clocks. Each qualified level change restarts a timeout counter. If `TIMEOUT_CYCLES` clocks pass with no qualified activity, the counter stops at its limit and `wdog_n` goes low. It stays low until activity returns.

The timer is held cleared in two cases: while the `hb_float` flag reports that the heartbeat source is undriven, and while the system reset from the reset sequencer (`sys_rst_n`) is low. It starts counting only once that reset is released. The output also acts as a low-line indicator. Whenever `supply_ok` is false, `wdog_n` is low whatever the timer state, so it stays low during power-up until the supply first becomes good.

Top module: `act_watchdog`

## Requirements
- R1: While `rst` is high, and on the first cycle after it, `wdog_n` is 0. A 0 on `wdog_n` means alarm or low line, and a 1 means healthy.
- R2: `supply_ok` low forces `wdog_n` to 0 from the next clock edge, regardless of the timer. When `supply_ok` rises with no pending timeout, `wdog_n` is 1 after the next edge.
- R3: While `sys_rst_n` is 0, the timer does not count, and `wdog_n` stays 1 (with `supply_ok` high) however long the reset lasts.
- R4: Once `sys_rst_n` is 1 with no activity, `wdog_n` is still 1 after `TIMEOUT_CYCLES` clock edges and is 0 after edge `TIMEOUT_CYCLES`+1. The edges are counted from the first edge that samples the release.
- R5: A level change on `hb_in` that holds for at least `GLITCH_CYCLES` clocks is activity. The timer restarts `GLITCH_CYCLES`+3 edges after the input changes, and the next timeout lands `TIMEOUT_CYCLES`+`GLITCH_CYCLES`+4 edges after the change.
- R6: A level change on `hb_in` that holds for `GLITCH_CYCLES`-1 clocks or fewer is ignored. It does not restart the timer and does not clear a timeout.
- R7: Activity after a timeout returns `wdog_n` to 1 `GLITCH_CYCLES`+4 edges after the input change, and the timer runs again.
- R8: While `hb_float` is 1, the timer is held cleared and `wdog_n` is 1 (with `supply_ok` high) from the second edge onward, even after a timeout. After `hb_float` falls, the timer behaves as in R4.
- R9: After a timeout, the counter saturates. `wdog_n` stays 0 for as long as no activity arrives and the timer stays enabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| hb_in | input | 1 | Asynchronous heartbeat from the processor |
| hb_float | input | 1 | 1 when the heartbeat source is undriven; disables the timer |
| sys_rst_n | input | 1 | Active-low system reset from the reset sequencer |
| supply_ok | input | 1 | Supply-good flag; 0 forces the output low |
| wdog_n | output | 1 | Registered active-low watchdog / low-line output |

## Verification
The properties assume that `rst` is high on the first clock and that all control inputs (`hb_float`, `sys_rst_n`, `supply_ok`) are synchronous to `clk`. Only `hb_in` may change freely, because it is the only input that passes through the synchronizer. The bench drives every input on the falling edge, so each value is stable at the sampling edge. It also holds each control level for at least two cycles, which the hold properties for float and system reset rely on. The glitch cases use pulse widths of `GLITCH_CYCLES`-1 and `GLITCH_CYCLES` clocks, so they sit exactly on either side of the qualification limit.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  typedef enum logic [1:0] {
    TMR_IDLE    = 2'd0,
    TMR_RUN     = 2'd1,
    TMR_EXPIRED = 2'd2
  } tmr_state_t;
endpackage

// File: rtl/hb_sync.sv
module hb_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] sr;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk) begin
        if (rst) sr <= '0;
        else     sr <= d;
      end
    end else begin : g_chain
      always_ff @(posedge clk) begin
        if (rst) sr <= '0;
        else     sr <= {sr[STAGES-2:0], d};
      end
    end
  endgenerate

  assign q = sr[STAGES-1];
endmodule

// File: rtl/hb_glitch_filter.sv
module hb_glitch_filter #(
  parameter int GLITCH_CYCLES = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic act
);
  localparam int GW = $clog2(GLITCH_CYCLES + 1);
  localparam logic [GW-1:0] LAST = GW'(GLITCH_CYCLES - 1);

  logic          level;
  logic [GW-1:0] run_cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      level   <= 1'b0;
      run_cnt <= '0;
      act     <= 1'b0;
    end else begin
      act <= 1'b0;
      if (din == level) begin
        run_cnt <= '0;
      end else if (run_cnt == LAST) begin
        level   <= din;
        run_cnt <= '0;
        act     <= 1'b1;
      end else begin
        run_cnt <= run_cnt + GW'(1);
      end
    end
  end
endmodule

// File: rtl/wdt_timer.sv
module wdt_timer
  import wdt_pkg::*;
#(
  parameter int TIMEOUT_CYCLES = 40
) (
  input  logic clk,
  input  logic rst,
  input  logic en,
  input  logic act,
  output logic expired
);
  localparam int CW = $clog2(TIMEOUT_CYCLES + 1);
  localparam logic [CW-1:0] LIMIT = CW'(TIMEOUT_CYCLES - 1);

  tmr_state_t    state;
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      state <= TMR_IDLE;
      cnt   <= '0;
    end else if (act) begin
      state <= TMR_RUN;
      cnt   <= '0;
    end else begin
      case (state)
        TMR_EXPIRED: begin
          state <= TMR_EXPIRED;
        end
        default: begin
          if (cnt == LIMIT) begin
            state <= TMR_EXPIRED;
          end else begin
            state <= TMR_RUN;
            cnt   <= cnt + CW'(1);
          end
        end
      endcase
    end
  end

  assign expired = (state == TMR_EXPIRED);
endmodule

// File: rtl/act_watchdog.sv
module act_watchdog #(
  parameter int SYNC_STAGES    = 2,
  parameter int GLITCH_CYCLES  = 4,
  parameter int TIMEOUT_CYCLES = 40
) (
  input  logic clk,
  input  logic rst,
  input  logic hb_in,
  input  logic hb_float,
  input  logic sys_rst_n,
  input  logic supply_ok,
  output logic wdog_n
);
  logic hb_s;
  logic act_pulse;
  logic timer_en;
  logic tmr_expired;

  hb_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   (hb_in),
    .q   (hb_s)
  );

  hb_glitch_filter #(.GLITCH_CYCLES(GLITCH_CYCLES)) u_filt (
    .clk (clk),
    .rst (rst),
    .din (hb_s),
    .act (act_pulse)
  );

  assign timer_en = sys_rst_n && !hb_float;

  wdt_timer #(.TIMEOUT_CYCLES(TIMEOUT_CYCLES)) u_tmr (
    .clk     (clk),
    .rst     (rst),
    .en      (timer_en),
    .act     (act_pulse),
    .expired (tmr_expired)
  );

  always_ff @(posedge clk) begin
    if (rst) wdog_n <= 1'b0;
    else     wdog_n <= supply_ok && !tmr_expired;
  end
endmodule

// File: rtl/act_watchdog_chk.sv
module act_watchdog_chk (
  input logic clk,
  input logic rst,
  input logic hb_float,
  input logic sys_rst_n,
  input logic supply_ok,
  input logic wdog_n,
  input logic expired,
  input logic act,
  input logic timer_en
);
  // R1
  p_reset_low_r1: assert property (@(posedge clk) rst |=> !wdog_n)
    else $error("p_reset_low_r1");

  // R2
  p_supply_low_r2: assert property (@(posedge clk) disable iff (rst)
    !supply_ok |=> !wdog_n)
    else $error("p_supply_low_r2");

  // R3
  p_sysrst_hold_r3: assert property (@(posedge clk) disable iff (rst)
    (!$past(sys_rst_n) && !sys_rst_n && supply_ok) |=> wdog_n)
    else $error("p_sysrst_hold_r3");

  // R4
  p_fall_cause_r4: assert property (@(posedge clk) disable iff (rst)
    $fell(wdog_n) |-> (!$past(supply_ok) || $past(expired)))
    else $error("p_fall_cause_r4");

  // R8
  p_float_high_r8: assert property (@(posedge clk) disable iff (rst)
    ($past(hb_float) && hb_float && supply_ok) |=> wdog_n)
    else $error("p_float_high_r8");

  // R9
  p_saturate_r9: assert property (@(posedge clk) disable iff (rst)
    (expired && timer_en && !act) |=> expired)
    else $error("p_saturate_r9");
endmodule

bind act_watchdog act_watchdog_chk u_chk (
  .clk       (clk),
  .rst       (rst),
  .hb_float  (hb_float),
  .sys_rst_n (sys_rst_n),
  .supply_ok (supply_ok),
  .wdog_n    (wdog_n),
  .expired   (tmr_expired),
  .act       (act_pulse),
  .timer_en  (timer_en)
);

// File: tb/tb_act_watchdog.sv
`timescale 1ns/1ps
module tb_act_watchdog;
  localparam int G = 4;
  localparam int T = 40;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic hb_in = 1'b0;
  logic hb_float = 1'b0;
  logic sys_rst_n = 1'b0;
  logic supply_ok = 1'b0;
  logic wdog_n;

  int n_checks = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  act_watchdog #(.SYNC_STAGES(2), .GLITCH_CYCLES(G), .TIMEOUT_CYCLES(T)) dut (
    .clk(clk), .rst(rst), .hb_in(hb_in), .hb_float(hb_float),
    .sys_rst_n(sys_rst_n), .supply_ok(supply_ok), .wdog_n(wdog_n)
  );

  task automatic chk(input logic exp, input string req);
    n_checks++;
    if (wdog_n !== exp) begin
      n_fail++;
      $display("FAIL %s: wdog_n=%b expected %b at %0t", req, wdog_n, exp, $time);
    end
  endtask

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic t_reset;
    cyc(3);
    chk(1'b0, "R1 in reset");
    rst = 1'b0;
    cyc(1);
    chk(1'b0, "R1 first cycle after reset");
  endtask

  task automatic t_powerup;
    for (int i = 0; i < 10; i++) begin
      cyc(1);
      chk(1'b0, "R2 supply not yet good");
    end
    supply_ok = 1'b1;
    cyc(1);
    chk(1'b1, "R2 supply good");
  endtask

  task automatic t_sysrst_hold;
    for (int i = 0; i < 3*T; i++) begin
      if (i == T) hb_in = ~hb_in;
      cyc(1);
      chk(1'b1, "R3 system reset holds timer");
    end
  endtask

  task automatic t_timeout;
    sys_rst_n = 1'b1;
    cyc(T);
    chk(1'b1, "R4 before timeout");
    cyc(1);
    chk(1'b0, "R4 at timeout");
  endtask

  task automatic t_saturate;
    for (int i = 0; i < 3*T; i++) begin
      cyc(1);
      chk(1'b0, "R9 timeout held");
    end
  endtask

  task automatic t_recover;
    hb_in = ~hb_in;
    for (int n = 1; n <= T+G+4; n++) begin
      cyc(1);
      if (n == G+4)        chk(1'b1, "R7 recovery");
      else if (n == G+3)   chk(1'b0, "R7 before recovery");
      else if (n == T+G+3) chk(1'b1, "R5 restart before timeout");
      else if (n == T+G+4) chk(1'b0, "R5 timeout after restart");
    end
  endtask

  task automatic t_periodic;
    hb_in = ~hb_in;
    cyc(G+4);
    chk(1'b1, "R5 periodic first recovery");
    for (int k = 0; k < 8; k++) begin
      for (int i = 0; i < T/2; i++) begin
        cyc(1);
        chk(1'b1, "R5 periodic heartbeat");
      end
      hb_in = ~hb_in;
    end
    cyc(T+G+6);
    chk(1'b0, "R5 periodic stop leads to timeout");
  endtask

  task automatic t_glitch;
    for (int k = 0; k < 10; k++) begin
      hb_in = ~hb_in;
      cyc(G-1);
      hb_in = ~hb_in;
      for (int i = 0; i < 5; i++) begin
        cyc(1);
        chk(1'b0, "R6 short pulse ignored");
      end
    end
    hb_in = ~hb_in;
    cyc(G);
    hb_in = ~hb_in;
    cyc(G+6);
    chk(1'b1, "R5 pulse of exact width qualifies");
    cyc(3*T);
    chk(1'b0, "R9 timeout after qualified pulse");
  endtask

  task automatic t_float;
    hb_float = 1'b1;
    cyc(2);
    chk(1'b1, "R8 float clears timeout");
    for (int i = 0; i < 3*T; i++) begin
      cyc(1);
      chk(1'b1, "R8 float holds timer");
    end
    hb_float = 1'b0;
    cyc(T);
    chk(1'b1, "R8 before timeout after float");
    cyc(1);
    chk(1'b0, "R8 timeout after float release");
  endtask

  task automatic t_supply;
    hb_in = ~hb_in;
    cyc(G+5);
    chk(1'b1, "R7 running before supply drop");
    supply_ok = 1'b0;
    cyc(1);
    chk(1'b0, "R2 supply drop");
    for (int i = 0; i < 10; i++) begin
      cyc(1);
      chk(1'b0, "R2 supply low");
    end
    supply_ok = 1'b1;
    cyc(1);
    chk(1'b1, "R2 supply restored");
  endtask

  task automatic finish_run;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  endtask

  initial begin
    t_reset();
    t_powerup();
    t_sysrst_hold();
    t_timeout();
    t_saturate();
    t_recover();
    t_periodic();
    t_glitch();
    t_float();
    t_supply();
    done = 1'b1;
    finish_run();
  end

  initial begin
    cyc(100000);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: run did not complete, actual hung expected done");
      finish_run();
    end
  end
endmodule